// File: doc/BRIEF.md
# Pin Expander Core with Change Interrupt

This block is an eight-pin general-purpose I/O controller that sits behind a simple host register bus. For each pin the host can choose a direction, drive an output level and read back the level seen at the pad. Every pin configured as an input is watched for level changes. A change latches a per-pin status flag, and a per-pin enable mask decides which of those flags raise the single host interrupt line.

Pad inputs pass through a two-stage synchronizer before they are used. The status flags are sticky. A read of the status register returns the flags and clears them. A change that lands in the same cycle as that read survives the clear. Each bus access can either name its address or continue at the address after the previous access, so the host can walk through consecutive registers in sequence.

Register map:

| Address | Register | Access |
|---------|----------|--------|
| 0x10 | Monitor (pin levels) | read only |
| 0x11 | Output level | read/write |
| 0x12 | Direction | read/write |
| 0x13 | Interrupt enable | read/write |
| 0x14 | Change status | read clears |

Bit n of every register belongs to pin n.

Top module: `pin_expander`

## Requirements
- R1: After reset is released, `oe_o`, `out_o` and `irq_o` are all zero, and the direction, output-level, enable and status registers all read 0. While `rst_ni` is low, `oe_o` is 0, so every pin is an input.
- R2: A read of address 0x10 returns the pad levels delayed by two clock edges, one bit per pin. A write to 0x10 changes nothing.
- R3: A write to 0x11 sets `out_o` to the written value. A read of 0x11 returns that value.
- R4: A write to 0x12 sets `oe_o` to the written value (1 = output, 0 = input). A read of 0x12 returns that value. The register changes only on such a write.
- R5: When `seq_i` is 1, an access ignores `addr_i` and uses the address of the previous access plus one. When `seq_i` is 0, the access uses `addr_i`. Every access, read or write, moves the stored address.
- R6: A level change on a pin whose direction bit is 0 sets that pin's status bit. The bit is visible three clock edges after the pad changes. A change on a pin whose direction bit is 1 sets nothing.
- R7: A status bit sets whether or not its enable bit is set, and stays set until the status register is read.
- R8: A read of 0x14 returns the status and clears it. A change detected in the cycle of that read is not in the returned value but stays set afterwards.
- R9: A write to 0x14 leaves the status register unchanged.
- R10: Address 0x13 holds the enable mask and reads back what was written. `irq_o` is 1 exactly when some pin has both its status bit and its enable bit set.
- R11: Read data appears on `rdata_o` on the clock edge that takes `re_i`, and holds until the next read. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address, used when `seq_i` is 0 |
| wdata_i | input | N_PINS | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| seq_i | input | 1 | Continue at the previous address plus one |
| rdata_o | output | N_PINS | Registered read data |
| pad_i | input | N_PINS | Pad levels, asynchronous |
| oe_o | output | N_PINS | Per-pin output enable |
| out_o | output | N_PINS | Per-pin output level |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. At that size all 256 values of the direction, output-level and pad buses can be swept. Every pin is toggled one at a time, with the mask both clear and set, so each status bit and each interrupt gate is reached on its own. The change that coincides with a status read is placed by counting synchronizer stages. Sequential chains are started from several addresses.

// File: rtl/pin_exp_pkg.sv
package pin_exp_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_MON = 8'h10;
  localparam logic [ADDR_W-1:0] A_OUT = 8'h11;
  localparam logic [ADDR_W-1:0] A_DIR = 8'h12;
  localparam logic [ADDR_W-1:0] A_MSK = 8'h13;
  localparam logic [ADDR_W-1:0] A_STS = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MON,
    SEL_OUT,
    SEL_DIR,
    SEL_MSK,
    SEL_STS
  } sel_e;

  function automatic sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      A_MON:   return SEL_MON;
      A_OUT:   return SEL_OUT;
      A_DIR:   return SEL_DIR;
      A_MSK:   return SEL_MSK;
      A_STS:   return SEL_STS;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pin_exp_sync.sv
module pin_exp_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      assign stg_d = d_i;
    end else begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_exp_chg.sv
module pin_exp_chg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] dir_i,
  input  logic         clr_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] sts_q;

  // prev tracks every pin so a direction flip never looks like a change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign edge_o = (lvl_i ^ prev_q) & ~dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (clr_i ? '0 : sts_q) | edge_o;
  end

  assign sts_o = sts_q;

  p_edge_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_o) |=> ((sts_o & $past(edge_o)) == $past(edge_o)));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

  p_clear_keeps_new_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sts_o == $past(edge_o)));
endmodule

// File: rtl/pin_exp_regs.sv
module pin_exp_regs
  import pin_exp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              seq_i,
  input  logic [W-1:0]      mon_i,
  input  logic [W-1:0]      sts_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      msk_o,
  output logic [W-1:0]      rdata_o,
  output logic              sts_rd_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [W-1:0]      dir_q, out_q, msk_q, rdata_q, rd_mux;
  logic              acc;
  sel_e              sel;

  assign eff_addr = seq_i ? ptr_q : addr_i;
  assign acc      = we_i | re_i;
  assign sel      = decode(eff_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (acc) ptr_q <= eff_addr + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      msk_q <= '0;
    end else if (we_i) begin
      if (sel == SEL_DIR) dir_q <= wdata_i;
      if (sel == SEL_OUT) out_q <= wdata_i;
      if (sel == SEL_MSK) msk_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MON: rd_mux = mon_i;
      SEL_OUT: rd_mux = out_q;
      SEL_DIR: rd_mux = dir_q;
      SEL_MSK: rd_mux = msk_q;
      SEL_STS: rd_mux = sts_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign msk_o    = msk_q;
  assign rdata_o  = rdata_q;
  assign sts_rd_o = re_i && (sel == SEL_STS);

  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (ptr_q == $past(eff_addr) + 1'b1));

  p_dir_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (sel == SEL_DIR)) |=> $stable(dir_o));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/pin_expander.sv
module pin_expander
  import pin_exp_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              seq_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] oe_o,
  output logic [N_PINS-1:0] out_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] lvl, dir, msk, sts, chg;
  logic              sts_rd;

  pin_exp_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (lvl)
  );

  pin_exp_chg #(.W(N_PINS)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .dir_i (dir),
    .clr_i (sts_rd),
    .sts_o (sts),
    .edge_o(chg)
  );

  pin_exp_regs #(.W(N_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .re_i    (re_i),
    .seq_i   (seq_i),
    .mon_i   (lvl),
    .sts_i   (sts),
    .dir_o   (dir),
    .out_o   (out_o),
    .msk_o   (msk),
    .rdata_o (rdata_o),
    .sts_rd_o(sts_rd)
  );

  assign oe_o  = dir;
  assign irq_o = |(sts & msk);

  always_comb begin
    if (!rst_ni) p_inputs_in_reset_r1: assert (oe_o == '0);
  end

  p_out_pin_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_rd |=> ((sts & ~$past(sts) & $past(dir)) == '0));
endmodule

// File: tb/pin_expander_bench.sv
module pin_expander_bench;
  import pin_exp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic [N-1:0] wdata = '0, pad = '0;
  logic         we = 1'b0, re = 1'b0, seq = 1'b0;
  logic [N-1:0] rdata, oe, outv;
  logic         irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_expander u_pin_expander (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .seq_i(seq), .rdata_o(rdata),
    .pad_i(pad), .oe_o(oe), .out_o(outv), .irq_o(irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d, input logic s);
    addr = a; wdata = d; seq = s; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; seq = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic s, output logic [N-1:0] d);
    addr = a; seq = s; re = 1'b1;
    @(posedge clk); @(negedge clk);
    re = 1'b0; seq = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    wait_cyc(2);
    check("R1 oe in reset", oe, '0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 oe", oe, '0);
    check("R1 out", outv, '0);
    check("R1 irq", {7'd0, irq}, '0);
    rd(A_DIR, 0, d); check("R1 dir", d, '0);
    rd(A_OUT, 0, d); check("R1 out reg", d, '0);
    rd(A_MSK, 0, d); check("R1 mask", d, '0);
    rd(A_STS, 0, d); check("R1 status", d, '0);

    // R3 / R4: sweep every value
    for (int v = 0; v < 256; v++) begin
      wr(A_OUT, v[7:0], 0);
      check("R3 out_o", outv, v[7:0]);
      rd(A_OUT, 0, d); check("R3 readback", d, v[7:0]);
    end
    wr(A_DIR, 8'hFF, 0);
    for (int v = 0; v < 256; v++) begin
      wr(A_DIR, v[7:0], 0);
      check("R4 oe_o", oe, v[7:0]);
      rd(A_DIR, 0, d); check("R4 readback", d, v[7:0]);
      rd(A_MON, 0, d);
      check("R4 dir unchanged by read", oe, v[7:0]);
    end

    // R2: pad levels (all outputs so no status noise)
    wr(A_DIR, 8'hFF, 0);
    for (int v = 0; v < 256; v++) begin
      pad = v[7:0];
      wait_cyc(2);
      rd(A_MON, 0, d); check("R2 monitor", d, v[7:0]);
    end
    wr(A_MON, ~pad, 0);
    rd(A_MON, 0, d); check("R2 write ignored", d, pad);

    // R6 output pins: no status
    rd(A_STS, 0, d); check("R6 no status from outputs", d, '0);
    pad = '0; wait_cyc(3);
    wr(A_DIR, 8'h00, 0);
    wait_cyc(3);
    rd(A_STS, 0, d); check("R6 dir flip no change", d, '0);

    // R6/R7/R10: per-pin toggles, mask clear then set
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(A_MSK, m ? (8'd1 << i) : 8'd0, 0);
        pad = pad ^ (8'd1 << i);
        wait_cyc(3);
        check("R10 irq", {7'd0, irq}, {7'd0, m[0]});
        rd(A_STS, 0, d); check("R6 R7 status bit", d, 8'd1 << i);
        check("R10 irq after clear", {7'd0, irq}, '0);
        rd(A_STS, 0, d); check("R8 cleared", d, '0);
      end
    end
    wr(A_MSK, 8'hA5, 0);
    rd(A_MSK, 0, d); check("R10 mask readback", d, 8'hA5);
    pad = pad ^ 8'h5A; wait_cyc(3);
    check("R10 irq masked out", {7'd0, irq}, '0);
    rd(A_STS, 0, d); check("R7 masked status", d, 8'h5A);

    // R6: mixed directions
    wr(A_DIR, 8'hF0, 0);
    pad = pad ^ 8'hFF; wait_cyc(3);
    rd(A_STS, 0, d); check("R6 input pins only", d, 8'h0F);

    // R9: write to status ignored
    pad = pad ^ 8'h03; wait_cyc(3);
    wr(A_STS, 8'h00, 0);
    wr(A_STS, 8'hFF, 0);
    rd(A_STS, 0, d); check("R9 write ignored", d, 8'h03);

    // R8: change lands on the read cycle
    pad = pad ^ 8'h04;
    wait_cyc(2);
    rd(A_STS, 0, d); check("R8 read misses new", d, '0);
    rd(A_STS, 0, d); check("R8 new bit kept", d, 8'h04);

    // R5: sequential access
    wr(A_OUT, 8'h3C, 0);
    wr(8'h00, 8'h0F, 1);
    check("R5 seq write dir", oe, 8'h0F);
    wr(8'h00, 8'h81, 1);
    rd(A_MSK, 0, d); check("R5 seq write mask", d, 8'h81);
    rd(A_MON, 0, d); check("R5 monitor", d, pad);
    rd(8'h00, 1, d); check("R5 seq read out", d, 8'h3C);
    rd(8'h00, 1, d); check("R5 seq read dir", d, 8'h0F);
    rd(8'h00, 1, d); check("R5 seq read mask", d, 8'h81);
    rd(8'h00, 1, d); check("R5 seq read status", d, '0);

    // R11: unmapped and hold
    rd(8'h20, 0, d); check("R11 unmapped", d, '0);
    rd(A_MSK, 0, d);
    wait_cyc(4);
    check("R11 data held", rdata, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule